// File: doc/BRIEF.md
# Big-Endian Sub-Word Load/Store Lane Merger

This block sits between a core's execute stage and a word-wide data memory. It takes a load or store request (opcode, base register value, 16-bit offset, source register value and register index), forms the effective address, and issues a read of the aligned word that contains it. It waits for the read data. It then extracts, extends or merges the addressed byte lanes to produce either a register write-back value or a full memory word to write back.

Every store is done as a read-modify-write on a whole word, so partial stores keep the lanes they do not touch. Byte lanes are big-endian: address offset 0 is bits [31:24] and offset 3 is bits [7:0]. The left/right word forms merge memory and register contents across a lane boundary. An unknown opcode is flagged and produces no memory access and no write-back.

Top module: `ldst_merge`

## Requirements
- R1: `mem_addr_o` equals `base_i` plus the sign-extended `imm_i`, with bits [1:0] forced to zero. It is valid and held steady while `mem_re_o` is high.
- R2: A legal request accepted while `ready_o` is high raises `mem_re_o` from the next cycle until the cycle `mem_rvalid_i` is seen. The store strobe `mem_we_o` or the write-back strobe `rd_we_o` is then high for exactly one cycle, the one right after the data is taken.
- R3: The byte loads (op 0x20 signed, 0x24 unsigned) return the byte at bit offset 24-8*ea[1:0]. The signed form sign-extends it and the unsigned form zero-extends it.
- R4: The halfword loads (op 0x21 signed, 0x25 unsigned) return bits [31:16] when ea[1]=0 and bits [15:0] when ea[1]=1. The signed form sign-extends and the unsigned form zero-extends.
- R5: The word load (op 0x23) and the linked load (op 0x30) return the memory word unchanged.
- R6: The left word load (op 0x22) returns the memory word shifted left by 8*ea[1:0]. The vacated low lanes are filled from `rt_val_i`.
- R7: The right word load (op 0x26) returns the memory word shifted right by 24-8*ea[1:0]. The vacated high lanes are filled from `rt_val_i`.
- R8: The byte store (op 0x28) and the halfword store (op 0x29) replace only the addressed lane of the fetched word with the low bits of `rt_val_i`. The lane positions are the same as in R3 and R4.
- R9: The left word store (op 0x2A) writes `rt_val_i` shifted right by 8*ea[1:0] into the low lanes and keeps the high memory lanes. The right word store (op 0x2E) writes `rt_val_i` shifted left by 24-8*ea[1:0] and keeps the low memory lanes.
- R10: The word store (op 0x2B) and the conditional store (op 0x38) write `rt_val_i`. Stores do not write back, except that the conditional store writes the value 1 to `rt_idx_i`.
- R11: No write-back strobe is raised when `rt_idx_i` is 0.
- R12: Any other opcode pulses `illegal_o` for one cycle after acceptance. It causes no read, no store and no write-back, and `ready_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, taken when `ready_o` is high |
| ready_o | output | 1 | Block idle and able to take a request |
| op_i | input | 6 | Major opcode |
| base_i | input | 32 | Base register value |
| imm_i | input | 16 | Signed address offset |
| rt_val_i | input | 32 | Source/target register value |
| rt_idx_i | input | 5 | Target register index |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_re_o | output | 1 | Read request, held until data returns |
| mem_rdata_i | input | 32 | Word read from memory |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_wdata_o | output | 32 | Merged word to write |
| mem_we_o | output | 1 | One-cycle store strobe |
| rd_we_o | output | 1 | One-cycle register write strobe |
| rd_idx_o | output | 5 | Register index to write |
| rd_data_o | output | 32 | Register write-back value |
| illegal_o | output | 1 | One-cycle unknown-opcode flag |

## Verification
The assertions assume that memory raises `mem_rvalid_i` only while `mem_re_o` is high. They also assume that `req_i` is only treated as accepted when `ready_o` is high. The stimulus respects both: it issues a new request only after the previous one has finished, and it raises `mem_rvalid_i` only during an outstanding read, sometimes after several wait cycles. Each lane case uses a distinct byte pattern in memory and in the register, so a wrong lane or shift shows up as a wrong value.

// File: rtl/ldst_merge_pkg.sv
package ldst_merge_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned OPW = 6;
  localparam int unsigned RIW = 5;

  localparam logic [OPW-1:0] OP_LB  = 6'h20;
  localparam logic [OPW-1:0] OP_LH  = 6'h21;
  localparam logic [OPW-1:0] OP_LWL = 6'h22;
  localparam logic [OPW-1:0] OP_LW  = 6'h23;
  localparam logic [OPW-1:0] OP_LBU = 6'h24;
  localparam logic [OPW-1:0] OP_LHU = 6'h25;
  localparam logic [OPW-1:0] OP_LWR = 6'h26;
  localparam logic [OPW-1:0] OP_SB  = 6'h28;
  localparam logic [OPW-1:0] OP_SH  = 6'h29;
  localparam logic [OPW-1:0] OP_SWL = 6'h2A;
  localparam logic [OPW-1:0] OP_SW  = 6'h2B;
  localparam logic [OPW-1:0] OP_SWR = 6'h2E;
  localparam logic [OPW-1:0] OP_LL  = 6'h30;
  localparam logic [OPW-1:0] OP_SC  = 6'h38;

  typedef enum logic [3:0] {
    K_BYTE_S, K_BYTE_U, K_HALF_S, K_HALF_U, K_WORD, K_LEFT_LD, K_RIGHT_LD,
    K_BYTE_ST, K_HALF_ST, K_WORD_ST, K_LEFT_ST, K_RIGHT_ST, K_COND_ST
  } acc_kind_e;

  typedef struct packed {
    logic      legal;
    logic      store;
    acc_kind_e kind;
  } acc_dec_t;

  typedef enum logic [0:0] {ST_IDLE, ST_READ} ctl_state_e;
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_merge_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  output acc_dec_t       dec_o
);
  always_comb begin
    dec_o = '{legal: 1'b1, store: 1'b0, kind: K_WORD};
    unique case (op_i)
      OP_LB:  dec_o.kind = K_BYTE_S;
      OP_LBU: dec_o.kind = K_BYTE_U;
      OP_LH:  dec_o.kind = K_HALF_S;
      OP_LHU: dec_o.kind = K_HALF_U;
      OP_LW, OP_LL: dec_o.kind = K_WORD;
      OP_LWL: dec_o.kind = K_LEFT_LD;
      OP_LWR: dec_o.kind = K_RIGHT_LD;
      OP_SB:  begin dec_o.kind = K_BYTE_ST;  dec_o.store = 1'b1; end
      OP_SH:  begin dec_o.kind = K_HALF_ST;  dec_o.store = 1'b1; end
      OP_SW:  begin dec_o.kind = K_WORD_ST;  dec_o.store = 1'b1; end
      OP_SWL: begin dec_o.kind = K_LEFT_ST;  dec_o.store = 1'b1; end
      OP_SWR: begin dec_o.kind = K_RIGHT_ST; dec_o.store = 1'b1; end
      OP_SC:  begin dec_o.kind = K_COND_ST;  dec_o.store = 1'b1; end
      default: dec_o.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/ldst_load_align.sv
module ldst_load_align
  import ldst_merge_pkg::*;
(
  input  acc_kind_e     kind_i,
  input  logic [1:0]    lo_i,
  input  logic [DW-1:0] mem_i,
  input  logic [DW-1:0] rt_i,
  output logic [DW-1:0] res_o
);
  logic [4:0]    lft_sh, lane_sh, half_sh;
  logic [7:0]    byte_v;
  logic [15:0]   half_v;
  logic [DW-1:0] lft_keep, rgt_keep;

  assign lft_sh   = {lo_i, 3'b000};
  assign lane_sh  = 5'd24 - lft_sh;
  assign half_sh  = lo_i[1] ? 5'd0 : 5'd16;
  assign byte_v   = 8'(mem_i >> lane_sh);
  assign half_v   = 16'(mem_i >> half_sh);
  // register lanes not overwritten by the shifted memory word
  assign lft_keep = ~({DW{1'b1}} << lft_sh);
  assign rgt_keep = ~({DW{1'b1}} >> lane_sh);

  always_comb begin
    unique case (kind_i)
      K_BYTE_S:   res_o = {{(DW-8){byte_v[7]}}, byte_v};
      K_BYTE_U:   res_o = {{(DW-8){1'b0}}, byte_v};
      K_HALF_S:   res_o = {{(DW-16){half_v[15]}}, half_v};
      K_HALF_U:   res_o = {{(DW-16){1'b0}}, half_v};
      K_LEFT_LD:  res_o = (mem_i << lft_sh) | (rt_i & lft_keep);
      K_RIGHT_LD: res_o = (mem_i >> lane_sh) | (rt_i & rgt_keep);
      default:    res_o = mem_i;
    endcase
  end
endmodule

// File: rtl/ldst_store_merge.sv
module ldst_store_merge
  import ldst_merge_pkg::*;
(
  input  acc_kind_e     kind_i,
  input  logic [1:0]    lo_i,
  input  logic [DW-1:0] mem_i,
  input  logic [DW-1:0] rt_i,
  output logic [DW-1:0] wdata_o
);
  logic [4:0]    lft_sh, lane_sh, half_sh;
  logic [DW-1:0] byte_m, half_m;

  assign lft_sh  = {lo_i, 3'b000};
  assign lane_sh = 5'd24 - lft_sh;
  assign half_sh = lo_i[1] ? 5'd0 : 5'd16;
  assign byte_m  = {{(DW-8){1'b0}}, 8'hFF} << lane_sh;
  assign half_m  = {{(DW-16){1'b0}}, 16'hFFFF} << half_sh;

  always_comb begin
    unique case (kind_i)
      K_BYTE_ST:  wdata_o = (mem_i & ~byte_m) | (({{(DW-8){1'b0}}, rt_i[7:0]} << lane_sh));
      K_HALF_ST:  wdata_o = (mem_i & ~half_m) | (({{(DW-16){1'b0}}, rt_i[15:0]} << half_sh));
      K_LEFT_ST:  wdata_o = (mem_i & ~({DW{1'b1}} >> lft_sh)) | (rt_i >> lft_sh);
      K_RIGHT_ST: wdata_o = (mem_i & ~({DW{1'b1}} << lane_sh)) | (rt_i << lane_sh);
      default:    wdata_o = rt_i;
    endcase
  end
endmodule

// File: rtl/ldst_merge.sv
module ldst_merge
  import ldst_merge_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  output logic           ready_o,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  base_i,
  input  logic [15:0]    imm_i,
  input  logic [DW-1:0]  rt_val_i,
  input  logic [RIW-1:0] rt_idx_i,
  output logic [DW-1:0]  mem_addr_o,
  output logic           mem_re_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_rvalid_i,
  output logic [DW-1:0]  mem_wdata_o,
  output logic           mem_we_o,
  output logic           rd_we_o,
  output logic [RIW-1:0] rd_idx_o,
  output logic [DW-1:0]  rd_data_o,
  output logic           illegal_o
);
  ctl_state_e     state_q;
  acc_dec_t       dec, dec_q;
  logic [DW-1:0]  ea, rt_q, ld_res, st_word;
  logic [1:0]     lo_q;
  logic [RIW-1:0] idx_q;
  logic           take, done;

  ldst_decode u_dec (.op_i(op_i), .dec_o(dec));

  ldst_load_align u_ld (
    .kind_i(dec_q.kind), .lo_i(lo_q), .mem_i(mem_rdata_i), .rt_i(rt_q), .res_o(ld_res)
  );

  ldst_store_merge u_st (
    .kind_i(dec_q.kind), .lo_i(lo_q), .mem_i(mem_rdata_i), .rt_i(rt_q), .wdata_o(st_word)
  );

  assign ea      = base_i + {{(DW-16){imm_i[15]}}, imm_i};
  assign ready_o = (state_q == ST_IDLE);
  assign take    = ready_o && req_i;
  assign done    = (state_q == ST_READ) && mem_rvalid_i;
  assign mem_re_o = (state_q == ST_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      dec_q      <= '{legal: 1'b0, store: 1'b0, kind: K_WORD};
      lo_q       <= '0;
      rt_q       <= '0;
      idx_q      <= '0;
      mem_addr_o <= '0;
    end else if (take) begin
      dec_q <= dec;
      if (dec.legal) begin
        state_q    <= ST_READ;
        lo_q       <= ea[1:0];
        rt_q       <= rt_val_i;
        idx_q      <= rt_idx_i;
        mem_addr_o <= {ea[DW-1:2], 2'b00};
      end
    end else if (done) begin
      state_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o    <= 1'b0;
      mem_wdata_o <= '0;
      rd_we_o     <= 1'b0;
      rd_idx_o    <= '0;
      rd_data_o   <= '0;
      illegal_o   <= 1'b0;
    end else begin
      mem_we_o  <= 1'b0;
      rd_we_o   <= 1'b0;
      illegal_o <= take && !dec.legal;
      if (done) begin
        rd_idx_o <= idx_q;
        if (dec_q.store) begin
          mem_we_o    <= 1'b1;
          mem_wdata_o <= st_word;
          // conditional store reports success in rt
          rd_we_o     <= (dec_q.kind == K_COND_ST) && (idx_q != '0);
          rd_data_o   <= {{(DW-1){1'b0}}, 1'b1};
        end else begin
          rd_we_o   <= (idx_q != '0);
          rd_data_o <= ld_res;
        end
      end
    end
  end
endmodule

// File: rtl/ldst_merge_chk.sv
module ldst_merge_chk
  import ldst_merge_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ready_o,
  input logic [DW-1:0]  mem_addr_o,
  input logic           mem_re_o,
  input logic           mem_rvalid_i,
  input logic           mem_we_o,
  input logic           rd_we_o,
  input logic [RIW-1:0] rd_idx_o,
  input logic           illegal_o
);
  assert_aligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> (mem_addr_o[1:0] == 2'b00));

  assert_addr_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && !mem_rvalid_i) |=> (mem_re_o && $stable(mem_addr_o)));

  assert_we_after_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o && mem_rvalid_i));

  assert_we_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  assert_wb_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |=> !rd_we_o);

  assert_no_r0_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (rd_idx_o != '0));

  assert_illegal_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!mem_we_o && !rd_we_o && !mem_re_o && ready_o));
endmodule

bind ldst_merge ldst_merge_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_o(ready_o), .mem_addr_o(mem_addr_o),
  .mem_re_o(mem_re_o), .mem_rvalid_i(mem_rvalid_i), .mem_we_o(mem_we_o),
  .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o), .illegal_o(illegal_o)
);

// File: tb/ldst_merge_tb.sv
`timescale 1ns/1ps
module ldst_merge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        ready;
  logic [5:0]  op = '0;
  logic [31:0] base = '0;
  logic [15:0] imm = '0;
  logic [31:0] rt_val = '0;
  logic [4:0]  rt_idx = '0;
  logic [31:0] maddr;
  logic        mre;
  logic [31:0] mrdata = '0;
  logic        mrvalid = 1'b0;
  logic [31:0] mwdata;
  logic        mwe;
  logic        rdwe;
  logic [4:0]  rdidx;
  logic [31:0] rddata;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ldst_merge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready), .op_i(op),
    .base_i(base), .imm_i(imm), .rt_val_i(rt_val), .rt_idx_i(rt_idx),
    .mem_addr_o(maddr), .mem_re_o(mre), .mem_rdata_i(mrdata), .mem_rvalid_i(mrvalid),
    .mem_wdata_o(mwdata), .mem_we_o(mwe), .rd_we_o(rdwe), .rd_idx_o(rdidx),
    .rd_data_o(rddata), .illegal_o(illegal)
  );

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  // Issue one access, optionally stall the read, then check both strobes and values.
  task automatic run_acc(string tag, logic [5:0] o, logic [31:0] b, logic [15:0] im,
                         logic [31:0] rt, logic [4:0] idx, logic [31:0] mem, int stall,
                         logic [31:0] exp_addr, logic exp_we, logic [31:0] exp_wd,
                         logic exp_rdwe, logic [31:0] exp_rd);
    @(negedge clk);
    op = o; base = b; imm = im; rt_val = rt; rt_idx = idx; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk({tag, " R2 read"}, {31'b0, mre}, 32'd1);
    chk({tag, " R1 addr"}, maddr, exp_addr);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk({tag, " R2 hold"}, {30'b0, mre, mwe | rdwe}, 32'd2);
      chk({tag, " R1 held"}, maddr, exp_addr);
    end
    mrdata = mem; mrvalid = 1'b1;
    @(negedge clk);
    mrvalid = 1'b0; mrdata = 32'hDEAD_BEEF;
    chk({tag, " R2 we"}, {31'b0, mwe}, {31'b0, exp_we});
    if (exp_we) chk({tag, " wdata"}, mwdata, exp_wd);
    chk({tag, " R11 rdwe"}, {31'b0, rdwe}, {31'b0, exp_rdwe});
    if (exp_rdwe) begin
      chk({tag, " rd data"}, rddata, exp_rd);
      chk({tag, " rd idx"}, {27'b0, rdidx}, {27'b0, idx});
    end
    @(negedge clk);
    chk({tag, " R2 pulse"}, {29'b0, mwe, rdwe, ready}, 32'd1);
  endtask

  task automatic t_reset();
    chk("reset R2", {28'b0, mre, mwe, rdwe, illegal}, 32'd0);
    chk("reset ready R2", {31'b0, ready}, 32'd1);
  endtask

  task automatic t_byte_loads();
    run_acc("R3 lb0", 6'h20, 32'h2000_0000, 16'h0, 32'hAABBCCDD, 5'd4, 32'h11223344, 0,
            32'h2000_0000, 0, 0, 1, 32'h0000_0011);
    run_acc("R3 lb1", 6'h20, 32'h2000_0001, 16'h0, 32'hAABBCCDD, 5'd4, 32'h11223344, 2,
            32'h2000_0000, 0, 0, 1, 32'h0000_0022);
    run_acc("R3 lb3 neg", 6'h20, 32'h2000_0003, 16'h0, 32'h0, 5'd4, 32'h112233F4, 0,
            32'h2000_0000, 0, 0, 1, 32'hFFFF_FFF4);
    run_acc("R3 lbu3", 6'h24, 32'h2000_0003, 16'h0, 32'h0, 5'd4, 32'h112233F4, 1,
            32'h2000_0000, 0, 0, 1, 32'h0000_00F4);
  endtask

  task automatic t_half_loads();
    run_acc("R4 lh0", 6'h21, 32'h3000_0000, 16'h0, 32'h0, 5'd7, 32'h88993344, 0,
            32'h3000_0000, 0, 0, 1, 32'hFFFF_8899);
    run_acc("R4 lhu2", 6'h25, 32'h3000_0002, 16'h0, 32'h0, 5'd7, 32'h1122B344, 0,
            32'h3000_0000, 0, 0, 1, 32'h0000_B344);
  endtask

  task automatic t_word_loads();
    run_acc("R5 lw imm+", 6'h23, 32'h0000_0100, 16'h0104, 32'h0, 5'd9, 32'h11223344, 0,
            32'h0000_0204, 0, 0, 1, 32'h11223344);
    run_acc("R5 ll imm-", 6'h30, 32'h1000_0003, 16'hFFFE, 32'h0, 5'd9, 32'hCAFE_F00D, 3,
            32'h1000_0000, 0, 0, 1, 32'hCAFE_F00D);
  endtask

  task automatic t_left_right_loads();
    run_acc("R6 lwl1", 6'h22, 32'h4000_0001, 16'h0, 32'hAABBCCDD, 5'd3, 32'h11223344, 0,
            32'h4000_0000, 0, 0, 1, 32'h223344DD);
    run_acc("R6 lwl0", 6'h22, 32'h4000_0000, 16'h0, 32'hAABBCCDD, 5'd3, 32'h11223344, 0,
            32'h4000_0000, 0, 0, 1, 32'h11223344);
    run_acc("R7 lwr1", 6'h26, 32'h4000_0001, 16'h0, 32'hAABBCCDD, 5'd3, 32'h11223344, 0,
            32'h4000_0000, 0, 0, 1, 32'hAABB1122);
    run_acc("R7 lwr3", 6'h26, 32'h4000_0003, 16'h0, 32'hAABBCCDD, 5'd3, 32'h11223344, 0,
            32'h4000_0000, 0, 0, 1, 32'h11223344);
  endtask

  task automatic t_part_stores();
    run_acc("R8 sb2", 6'h28, 32'h5000_0002, 16'h0, 32'hAABBCCDD, 5'd6, 32'h11223344, 1,
            32'h5000_0000, 1, 32'h1122DD44, 0, 0);
    run_acc("R8 sh0", 6'h29, 32'h5000_0000, 16'h0, 32'hAABBCCDD, 5'd6, 32'h11223344, 0,
            32'h5000_0000, 1, 32'hCCDD3344, 0, 0);
    run_acc("R8 sh2", 6'h29, 32'h5000_0002, 16'h0, 32'hAABBCCDD, 5'd6, 32'h11223344, 0,
            32'h5000_0000, 1, 32'h1122CCDD, 0, 0);
  endtask

  task automatic t_left_right_stores();
    run_acc("R9 swl1", 6'h2A, 32'h6000_0001, 16'h0, 32'hAABBCCDD, 5'd2, 32'h11223344, 0,
            32'h6000_0000, 1, 32'h11AABBCC, 0, 0);
    run_acc("R9 swl0", 6'h2A, 32'h6000_0000, 16'h0, 32'hAABBCCDD, 5'd2, 32'h11223344, 0,
            32'h6000_0000, 1, 32'hAABBCCDD, 0, 0);
    run_acc("R9 swr1", 6'h2E, 32'h6000_0001, 16'h0, 32'hAABBCCDD, 5'd2, 32'h11223344, 0,
            32'h6000_0000, 1, 32'hCCDD3344, 0, 0);
    run_acc("R9 swr3", 6'h2E, 32'h6000_0003, 16'h0, 32'hAABBCCDD, 5'd2, 32'h11223344, 2,
            32'h6000_0000, 1, 32'hAABBCCDD, 0, 0);
  endtask

  task automatic t_word_stores();
    run_acc("R10 sw", 6'h2B, 32'h7000_0008, 16'h0, 32'hAABBCCDD, 5'd5, 32'h11223344, 0,
            32'h7000_0008, 1, 32'hAABBCCDD, 0, 0);
    run_acc("R10 sc", 6'h38, 32'h7000_0008, 16'h0, 32'hAABBCCDD, 5'd5, 32'h11223344, 0,
            32'h7000_0008, 1, 32'hAABBCCDD, 1, 32'h0000_0001);
  endtask

  task automatic t_reg_zero();
    run_acc("R11 lw r0", 6'h23, 32'h8000_0000, 16'h0, 32'h0, 5'd0, 32'h11223344, 0,
            32'h8000_0000, 0, 0, 0, 0);
    run_acc("R11 sc r0", 6'h38, 32'h8000_0000, 16'h0, 32'h55, 5'd0, 32'h11223344, 0,
            32'h8000_0000, 1, 32'h0000_0055, 0, 0);
  endtask

  task automatic t_illegal();
    @(negedge clk);
    op = 6'h3F; base = 32'h9000_0000; imm = '0; rt_idx = 5'd8; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R12 flag", {31'b0, illegal}, 32'd1);
    chk("R12 quiet", {29'b0, mre, mwe, rdwe}, 32'd0);
    chk("R12 ready", {31'b0, ready}, 32'd1);
    @(negedge clk);
    chk("R12 pulse", {28'b0, illegal, mre, mwe, rdwe}, 32'd0);
  endtask

  initial begin
    #25;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_loads();
    t_half_loads();
    t_word_loads();
    t_left_right_loads();
    t_part_stores();
    t_left_right_stores();
    t_word_stores();
    t_reg_zero();
    t_illegal();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule